// File: doc/BRIEF.md
# Memory BAR Bank with Size Discovery and Address Decode

This block holds the six dword-wide base address slots of a Type 0 configuration header. It lets host software find out the size of each memory aperture, program it, and have incoming bus addresses decoded against it. The set of implemented slots, each aperture size (as a power of two), the 64-bit flag and the prefetchable flag are fixed when the block is elaborated. A 64-bit BAR uses its own slot and the slot above it. That upper slot holds address bits 63:32 and has no type bits of its own.

Software reads and writes the bank one dword at a time. It picks a slot by index and can update single byte lanes. Read data is combinational in the same cycle. Bits below the aperture size cannot be written, so writing all ones and reading back shows the size. A slot that is not implemented always reads zero. A separate decode port compares a 64-bit bus address with every programmed BAR and raises one hit bit per BAR. A BAR whose whole address is zero never hits, so every BAR is disabled after reset until software programs it. The deassertion of `rst_n` must already be synchronous to `clk`.

Top module: `membar_bank`

## Requirements
- R1: A slot that is not implemented (default: indices 3 and 5) reads 0x00000000 and ignores writes, including an all-ones write.
- R2: In an implemented base slot, the address bits below the aperture size read as zero and cannot be written. After an all-ones write the slot reads ~(2^size-1) together with its type bits (default: slot 0 reads 0xFFFFF000, slot 4 reads 0xFFFFFFF0, slot 1 reads 0xFFF0000C).
- R3: Base slot type bits are read-only. Bit 0 is 0 (memory space), bits [2:1] are 00 for a 32-bit BAR and 10 for a 64-bit BAR, and bit 3 is the prefetchable setting. By default slot 1 reads low nibble 0xC after a zero write.
- R4: The slot above a 64-bit BAR (default: slot 2) is fully writable, carries no type bits, and supplies address bits 63:32. A 64-bit flag on the last slot is ignored.
- R5: After reset every address field is zero: each slot reads only its type bits, and no hit is raised.
- R6: A configuration write updates only the byte lanes whose enable bit is set (bit n covers data bits 8n+7:8n).
- R7: hit[i] is raised in the same cycle when mem_en is high, BAR i's address is nonzero, and the bus address equals the BAR address on all bits at or above the aperture size. A 32-bit BAR matches only addresses below 4 GiB.
- R8: A BAR whose address is zero never hits. A 64-bit BAR counts as zero only when both of its dwords are zero, so a zero lower dword with a nonzero upper dword still decodes.
- R9: With mem_en low, every hit bit is low.
- R10: The hit bit of an upper-half slot and of an unimplemented slot is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr | input | 1 | Configuration write strobe for the selected slot |
| cfg_idx | input | 3 | Slot index 0..5; indices 6 and 7 read zero and write nothing |
| cfg_be | input | 4 | Byte-lane enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected slot, combinational |
| mem_en | input | 1 | Memory-space decode enable |
| dec_addr | input | 64 | Bus address to decode |
| dec_hit | output | 6 | One hit bit per slot, set only on base slots |

## Verification
Read data and hit bits are combinational. The bench changes index or address on a falling edge and samples one time step later, with no clock edge in between. A write takes effect at the rising edge on which `cfg_wr` is sampled high. Every check that depends on a write therefore waits for that edge and the following falling edge before it samples. Decode checks run only after the write cycles that set the BAR addresses have completed.

// File: rtl/membar_pkg.sv
package membar_pkg;
  localparam int NSLOT = 6;
  localparam int DW    = 32;
  localparam int LGW   = 6;

  typedef logic [NSLOT-1:0]     slot_vec_t;
  typedef logic [NSLOT*LGW-1:0] lg_vec_t;
  typedef logic [DW-1:0]        dword_t;

  // Slots that act as the upper dword of a 64-bit BAR, resolved bottom-up.
  function automatic slot_vec_t upper_vec(slot_vec_t impl, slot_vec_t wide);
    slot_vec_t u;
    u = '0;
    for (int i = 0; i < NSLOT-1; i++)
      if (!u[i] && impl[i] && wide[i]) u[i+1] = 1'b1;
    return u;
  endfunction

  function automatic slot_vec_t base_vec(slot_vec_t impl, slot_vec_t wide);
    return impl & ~upper_vec(impl, wide);
  endfunction

  function automatic slot_vec_t lower64_vec(slot_vec_t impl, slot_vec_t wide);
    slot_vec_t b;
    b = base_vec(impl, wide);
    return {1'b0, b[NSLOT-2:0] & wide[NSLOT-2:0]};
  endfunction

  function automatic int lg_of(lg_vec_t lg, int i);
    return int'(lg[i*LGW +: LGW]);
  endfunction

  function automatic logic [63:0] amask64(lg_vec_t lg, int i);
    return ~((64'd1 << lg_of(lg, i)) - 64'd1);
  endfunction

  function automatic dword_t wmask_of(slot_vec_t impl, slot_vec_t wide,
                                      lg_vec_t lg, int i);
    slot_vec_t u, b;
    logic [63:0] m;
    u = upper_vec(impl, wide);
    b = base_vec(impl, wide);
    if (u[i]) begin
      m = amask64(lg, i-1);
      return m[63:32];
    end
    if (b[i]) begin
      m = amask64(lg, i);
      return m[31:0];
    end
    return '0;
  endfunction

  function automatic dword_t fixed_of(slot_vec_t impl, slot_vec_t wide,
                                      slot_vec_t pref, int i);
    slot_vec_t b, l;
    b = base_vec(impl, wide);
    l = lower64_vec(impl, wide);
    if (!b[i]) return '0;
    return {28'd0, pref[i], l[i], 1'b0, 1'b0};
  endfunction
endpackage

// File: rtl/bar_slot_reg.sv
module bar_slot_reg
  import membar_pkg::*;
#(
  parameter dword_t WMASK = '0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  logic [3:0] be,
  input  dword_t wdata,
  output dword_t q
);
  dword_t lane_mask, upd, q_nxt;

  always_comb begin
    for (int b = 0; b < 4; b++) lane_mask[b*8 +: 8] = {8{be[b]}};
    upd   = lane_mask & WMASK;
    q_nxt = (q & ~upd) | (wdata & upd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= q_nxt;
  end
endmodule

// File: rtl/bar_hit_unit.sv
module bar_hit_unit
  import membar_pkg::*;
#(
  parameter int LG   = 12,
  parameter bit WIDE = 1'b0
) (
  input  logic        mem_en,
  input  dword_t      lo,
  input  dword_t      hi,
  input  logic [63:0] addr,
  output logic        hit
);
  localparam logic [63:0] AMASK = ~((64'd1 << LG) - 64'd1);
  logic [63:0] base;

  always_comb begin
    base = {(WIDE ? hi : 32'd0), lo};
    hit  = mem_en && (base != 64'd0) && ((addr & AMASK) == base);
  end
endmodule

// File: rtl/membar_bank.sv
module membar_bank
  import membar_pkg::*;
#(
  parameter slot_vec_t IMPL     = 6'b010011,
  parameter slot_vec_t WIDE     = 6'b000010,
  parameter slot_vec_t PREF     = 6'b000010,
  parameter lg_vec_t   APERTURE = {6'd4, 6'd4, 6'd4, 6'd4, 6'd20, 6'd12}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [2:0]  cfg_idx,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        mem_en,
  input  logic [63:0] dec_addr,
  output logic [5:0]  dec_hit
);
  localparam slot_vec_t BASE = base_vec(IMPL, WIDE);
  localparam slot_vec_t LO64 = lower64_vec(IMPL, WIDE);

  dword_t    q [NSLOT];
  dword_t    fixed [NSLOT];
  slot_vec_t wr_sel;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam dword_t WM = wmask_of(IMPL, WIDE, APERTURE, i);
    assign fixed[i]  = fixed_of(IMPL, WIDE, PREF, i);
    assign wr_sel[i] = cfg_wr && (cfg_idx == 3'(i));

    bar_slot_reg #(.WMASK(WM)) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(wr_sel[i]),
      .be   (cfg_be),
      .wdata(cfg_wdata),
      .q    (q[i])
    );

    if (BASE[i]) begin : g_dec
      localparam int HI = (i < NSLOT-1) ? i+1 : i;
      bar_hit_unit #(.LG(lg_of(APERTURE, i)), .WIDE(LO64[i])) u_hit (
        .mem_en(mem_en),
        .lo    (q[i]),
        .hi    (q[HI]),
        .addr  (dec_addr),
        .hit   (dec_hit[i])
      );
    end else begin : g_nodec
      assign dec_hit[i] = 1'b0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NSLOT; i++)
      if (cfg_idx == 3'(i)) cfg_rdata = q[i] | fixed[i];
  end
endmodule

// File: rtl/membar_bank_chk.sv
module membar_bank_chk
  import membar_pkg::*;
#(
  parameter slot_vec_t IMPL     = 6'b010011,
  parameter slot_vec_t WIDE     = 6'b000010,
  parameter slot_vec_t PREF     = 6'b000010,
  parameter lg_vec_t   APERTURE = {6'd4, 6'd4, 6'd4, 6'd4, 6'd20, 6'd12}
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [2:0]  cfg_idx,
  input logic [31:0] cfg_rdata,
  input logic        mem_en,
  input logic [63:0] dec_addr,
  input logic [5:0]  dec_hit
);
  localparam slot_vec_t BASE = base_vec(IMPL, WIDE);
  localparam slot_vec_t LO64 = lower64_vec(IMPL, WIDE);

  logic idx_ok;
  assign idx_ok = cfg_idx < 3'(NSLOT);

  // R1
  p_absent_reads_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_ok && !IMPL[cfg_idx] && !upper_vec(IMPL, WIDE)[cfg_idx]) |-> cfg_rdata == '0);

  // R2
  p_low_bits_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ok |-> ((cfg_rdata & ~wmask_of(IMPL, WIDE, APERTURE, int'(cfg_idx)))
                == fixed_of(IMPL, WIDE, PREF, int'(cfg_idx))));

  // R3
  p_type_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_ok && BASE[cfg_idx]) |->
      (cfg_rdata[0] == 1'b0 && cfg_rdata[2:1] == {LO64[cfg_idx], 1'b0}
       && cfg_rdata[3] == PREF[cfg_idx]));

  // R6
  p_hold_without_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> (cfg_idx != $past(cfg_idx) || cfg_rdata == $past(cfg_rdata)));

  // R9
  p_enable_gates_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en |-> dec_hit == '0);

  // R10
  p_nonbase_no_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_hit & ~BASE) == '0);

  for (genvar k = 0; k < NSLOT; k++) begin : g_k
    localparam logic [63:0] AM = amask64(APERTURE, k);
    // R8
    p_zero_no_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hit[k] |-> (dec_addr & AM) != 64'd0);
  end
endmodule

bind membar_bank membar_bank_chk #(
  .IMPL(IMPL), .WIDE(WIDE), .PREF(PREF), .APERTURE(APERTURE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
  .cfg_rdata(cfg_rdata), .mem_en(mem_en), .dec_addr(dec_addr),
  .dec_hit(dec_hit)
);

// File: tb/sim_membar_bank.sv
module sim_membar_bank;
  localparam int TCLK = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [2:0]  cfg_idx;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        mem_en;
  logic [63:0] dec_addr;
  logic [5:0]  dec_hit;

  int n_chk = 0;
  int n_bad = 0;

  always #(TCLK/2) clk = ~clk;

  membar_bank u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_en(mem_en), .dec_addr(dec_addr), .dec_hit(dec_hit)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    cfg_idx = 3'(idx); cfg_wdata = d; cfg_be = be; cfg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, int idx, logic [31:0] exp);
    @(negedge clk);
    cfg_idx = 3'(idx);
    #1;
    chk(req, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic hit_chk(string req, logic [63:0] a, logic [5:0] exp);
    @(negedge clk);
    dec_addr = a;
    #1;
    chk(req, 64'(dec_hit), 64'(exp));
  endtask

  task automatic t_reset;
    rd_chk("R5 slot0", 0, 32'h0);
    rd_chk("R5 slot1", 1, 32'h0000000C);
    rd_chk("R5 slot2", 2, 32'h0);
    rd_chk("R5 slot4", 4, 32'h0);
    hit_chk("R5 no hit", 64'h0, 6'b0);
  endtask

  task automatic t_absent;
    wr(3, 32'hFFFFFFFF);
    rd_chk("R1 slot3", 3, 32'h0);
    wr(5, 32'hFFFFFFFF);
    rd_chk("R1 slot5", 5, 32'h0);
  endtask

  task automatic t_sizing;
    wr(0, 32'hFFFFFFFF); rd_chk("R2 slot0 4KiB", 0, 32'hFFFFF000);
    wr(4, 32'hFFFFFFFF); rd_chk("R2 slot4 16B", 4, 32'hFFFFFFF0);
    wr(1, 32'hFFFFFFFF); rd_chk("R2 slot1 1MiB", 1, 32'hFFF0000C);
    wr(0, 32'h0); wr(4, 32'h0);
  endtask

  task automatic t_type;
    wr(1, 32'h0);
    rd_chk("R3 64-bit prefetch type", 1, 32'h0000000C);
    wr(0, 32'h0000000F);
    rd_chk("R3 32-bit type read-only", 0, 32'h0);
  endtask

  task automatic t_pair;
    wr(2, 32'hFFFFFFFF);
    rd_chk("R4 upper fully writable", 2, 32'hFFFFFFFF);
  endtask

  task automatic t_bytes;
    wr(2, 32'h12345678, 4'b0101);
    rd_chk("R6 lanes 0,2", 2, 32'hFF34FF78);
    wr(2, 32'hAB000000, 4'b1000);
    rd_chk("R6 lane 3", 2, 32'hAB34FF78);
  endtask

  task automatic t_decode;
    mem_en = 1'b1;
    wr(0, 32'h80000000); wr(1, 32'h0); wr(2, 32'h1); wr(4, 32'h10);
    hit_chk("R7 slot0 inside", 64'h0000_0000_8000_0ABC, 6'b000001);
    hit_chk("R7 slot0 outside", 64'h0000_0000_8000_1000, 6'b000000);
    hit_chk("R10 64-bit hit on lower only", 64'h0000_0001_0001_2345, 6'b000010);
    hit_chk("R7 slot4", 64'h0000_0000_0000_001F, 6'b010000);
    hit_chk("R7 32-bit above 4GiB", 64'h0000_0001_8000_0ABC, 6'b000000);
  endtask

  task automatic t_zero;
    hit_chk("R8 upper only nonzero", 64'h0000_0001_000F_FFFF, 6'b000010);
    wr(2, 32'h0);
    hit_chk("R8 64-bit both zero", 64'h0000_0000_000F_0000, 6'b000000);
    wr(0, 32'h0);
    hit_chk("R8 32-bit zero", 64'h0000_0000_0000_0123, 6'b000000);
  endtask

  task automatic t_enable;
    wr(0, 32'h80000000);
    mem_en = 1'b0;
    hit_chk("R9 disabled", 64'h0000_0000_8000_0ABC, 6'b000000);
    mem_en = 1'b1;
    hit_chk("R9 enabled", 64'h0000_0000_8000_0ABC, 6'b000001);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_idx = '0; cfg_be = '0;
    cfg_wdata = '0; mem_en = 1'b1; dec_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_absent();
    t_sizing();
    t_type();
    t_pair();
    t_bytes();
    t_decode();
    t_zero();
    t_enable();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(TCLK * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule